// File: doc/BRIEF.md
# Flash Block-Erase Command Controller

This block is the command front end of a small behavioural NOR-style flash array. A host writes command bytes, each tagged with a block number, over a valid/ready channel. The controller decodes them into a two-write erase sequence, suspend and resume of a running erase, status and array read-mode selection, and clearing of sticky error flags. A confirmed erase walks the chosen block through three timed phases: first every word is forced to zero, then every word becomes all ones, and a final verify interval closes the operation.

Reads are combinational. Depending on the current read mode, `rd_data` returns either the status byte, zero-extended, or the array word at `rd_addr`. The `sts_ready` pin is low only while an erase is actually running. The erase is abandoned if the target block's lock bit is set, if `vpen_ok` falls while the erase runs or sits suspended, or if `dev_rst` is pulsed. A reset pulse leaves the target block holding a fixed garbage word.

Command channel rules: a command is taken on a rising clock edge only when `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low exactly while `dev_rst` is high. The host must hold `cmd_code` and `cmd_blk` stable while `cmd_valid` waits, and a refused beat has no effect.

Top module: `blk_erase_ctrl`

## Requirements
- R1: After `rst_n` the controller is idle with `sts_ready` = 1 and array read mode, and word address i (address = block*WORDS_PER_BLK + word) reads 0x4000 + (i / WORDS_PER_BLK)*0x100 + (i mod WORDS_PER_BLK).
- R2: Command 0x20 followed by 0xD0 (its `cmd_blk` selects the block) keeps `sts_ready` low for exactly 3*PHASE_CYCLES clock cycles from the confirm edge. Afterwards every word of that block reads 0xFFFF, and other blocks are unchanged.
- R3: The first PHASE_CYCLES cycles of an erase end with every word of the target block set to 0x0000. The second phase ends with 0xFFFF, and the third only waits.
- R4: Status byte layout is bit7 ready, bit6 erase suspended, bit5 erase error, bit4 sequence error, bit3 voltage error and bit1 lock error, with the other bits zero. Writing 0x20 selects status read mode, and that mode stays in force after the erase finishes until 0xFF (array mode) is written. Writing 0x70 also selects status mode.
- R5: While an erase runs, only 0x70, 0xB0 and 0xFF have any effect; every other code is ignored. In array mode during a running erase, `rd_data` returns the invalid marker 0xDEAD.
- R6: 0xB0 during a run suspends it: `sts_ready` rises and status bit6 is set. Array reads are valid while suspended. 0xD0 resumes from the saved point, so the total busy time stays 3*PHASE_CYCLES.
- R7: A confirm naming a locked block, or the target's lock bit rising during a run or suspend, ends the operation with status bits 5 and 1 set, and a locked confirm leaves the block untouched.
- R8: `vpen_ok` low at confirm, or falling during a run or suspend, ends the operation with status bits 5 and 3 set.
- R9: A write other than 0xD0 directly after 0x20 sets status bits 5 and 4 and returns to idle.
- R10: While any error bit is set, 0x20 is ignored (read mode unchanged, no erase). 0x50 clears all error bits when not running.
- R11: While `prog_susp` is high, 0x20 is ignored.
- R12: A `dev_rst` cycle during a run or suspend fills the target block with 0x5A5A. It also returns the controller to idle with error bits cleared and array read mode.
- R13: No command is taken while `cmd_ready` is low (`dev_rst` high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous power-on reset, loads the seed pattern |
| dev_rst | input | 1 | Active-high device reset, aborts an erase and garbles its block |
| cmd_valid | input | 1 | Command beat offered |
| cmd_ready | output | 1 | Command beat can be taken |
| cmd_code | input | 8 | Command byte |
| cmd_blk | input | $clog2(NUM_BLKS) | Block number carried by the command |
| rd_addr | input | $clog2(NUM_BLKS)+$clog2(WORDS_PER_BLK) | Array word address for reads |
| rd_data | output | DATA_W | Status byte or array word, by read mode |
| vpen_ok | input | 1 | Programming voltage is valid |
| prog_susp | input | 1 | A program operation is suspended elsewhere |
| lock_mask | input | NUM_BLKS | One lock bit per block |
| sts_ready | output | 1 | High unless an erase is running |

## Verification
The bench aims at the points where priorities collide. These include a lock bit or voltage drop arriving while the erase is suspended, and a reset pulse landing mid-phase together with a refused command. It also covers a suspend timed inside the second phase, where a design that did not save its position would either restart the count, giving the wrong busy length, or skip the zero-fill, leaving old data visible. Commands that must be ignored during a run (clear, a second setup, a stray confirm) are issued to show that a design accepting them would drop busy early or corrupt the status byte. Sticky errors and a suspended program must each block a new setup; a design that let one through would switch to status mode, and the next array read would expose that.

// File: rtl/bec_pkg.sv
`timescale 1ns/1ps
package bec_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_RUN, ST_SUSP} seq_state_e;
  typedef enum logic [1:0] {PH_PRE, PH_ERASE, PH_VERIFY} phase_e;

  localparam logic [7:0] CMD_SETUP   = 8'h20;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_SUSPEND = 8'hB0;
  localparam logic [7:0] CMD_RDSTAT  = 8'h70;
  localparam logic [7:0] CMD_CLEAR   = 8'h50;
  localparam logic [7:0] CMD_RDARR   = 8'hFF;

  localparam logic [7:0] ERR_ERASE = 8'h20;
  localparam logic [7:0] ERR_SEQ   = 8'h10;
  localparam logic [7:0] ERR_VPEN  = 8'h08;
  localparam logic [7:0] ERR_LOCK  = 8'h02;
endpackage

// File: rtl/bec_timer.sv
`timescale 1ns/1ps
// Phase sequencer: holds phase and remaining count; both freeze whenever
// advance is low, which is how a suspend keeps its place.
module bec_timer
  import bec_pkg::*;
#(
  parameter int PHASE_CYCLES = 16
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   advance,
  output phase_e phase,
  output logic   phase_end
);
  localparam int CNT_W = $clog2(PHASE_CYCLES + 1);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(PHASE_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  phase_e           phase_q;

  assign phase     = phase_q;
  assign phase_end = advance && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_PRE;
      cnt_q   <= '0;
    end else if (start) begin
      phase_q <= PH_PRE;
      cnt_q   <= RELOAD;
    end else if (advance) begin
      if (cnt_q == '0) begin
        cnt_q <= RELOAD;
        case (phase_q)
          PH_PRE:   phase_q <= PH_ERASE;
          PH_ERASE: phase_q <= PH_VERIFY;
          default:  phase_q <= PH_VERIFY;
        endcase
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/bec_array.sv
`timescale 1ns/1ps
// Behavioural storage with a whole-block fill port and one read port.
module bec_array #(
  parameter int DATA_W        = 16,
  parameter int NUM_BLKS      = 4,
  parameter int WORDS_PER_BLK = 8,
  localparam int BLK_W  = $clog2(NUM_BLKS),
  localparam int WRD_W  = $clog2(WORDS_PER_BLK),
  localparam int ADDR_W = BLK_W + WRD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_en,
  input  logic [BLK_W-1:0]  fill_blk,
  input  logic [DATA_W-1:0] fill_val,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_word
);
  localparam int DEPTH = NUM_BLKS * WORDS_PER_BLK;

  logic [DATA_W-1:0] mem [DEPTH];

  function automatic logic [DATA_W-1:0] seed_word(input int idx);
    return DATA_W'(32'h4000 + (idx / WORDS_PER_BLK) * 32'h100 + (idx % WORDS_PER_BLK));
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= seed_word(i);
    end else if (fill_en) begin
      for (int w = 0; w < WORDS_PER_BLK; w++) mem[{fill_blk, WRD_W'(w)}] <= fill_val;
    end
  end

  assign rd_word = mem[rd_addr];
endmodule

// File: rtl/bec_seq.sv
`timescale 1ns/1ps
// Command decoder, operation state, sticky error flags and read mode.
module bec_seq
  import bec_pkg::*;
#(
  parameter int NUM_BLKS = 4,
  localparam int BLK_W = $clog2(NUM_BLKS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                dev_rst,
  input  logic                cmd_acc,
  input  logic [7:0]          cmd_code,
  input  logic [BLK_W-1:0]    cmd_blk,
  input  logic                vpen_ok,
  input  logic                prog_susp,
  input  logic [NUM_BLKS-1:0] lock_mask,
  input  logic                op_last,
  output seq_state_e          state_o,
  output logic [7:0]          status_o,
  output logic                mode_stat_o,
  output logic [BLK_W-1:0]    blk_o,
  output logic                start_o,
  output logic                advance_o,
  output logic                garbage_o
);
  seq_state_e       st_q;
  logic [7:0]       err_q;
  logic             mode_q;
  logic [BLK_W-1:0] blk_q;
  logic             active, lock_now, abort;

  assign active    = (st_q == ST_RUN) || (st_q == ST_SUSP);
  assign lock_now  = lock_mask[blk_q];
  assign abort     = active && (!vpen_ok || lock_now);
  assign advance_o = (st_q == ST_RUN) && !dev_rst && !abort;
  assign start_o   = !dev_rst && (st_q == ST_SETUP) && cmd_acc && (cmd_code == CMD_CONFIRM)
                     && !lock_mask[cmd_blk] && vpen_ok;
  assign garbage_o = dev_rst && active;

  assign state_o     = st_q;
  assign mode_stat_o = mode_q;
  assign blk_o       = blk_q;
  assign status_o    = err_q | {(st_q != ST_RUN), (st_q == ST_SUSP), 6'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      err_q  <= '0;
      mode_q <= 1'b0;
      blk_q  <= '0;
    end else if (dev_rst) begin
      st_q   <= ST_IDLE;
      err_q  <= '0;
      mode_q <= 1'b0;
    end else if (abort) begin
      st_q  <= ST_IDLE;
      err_q <= err_q | ERR_ERASE | (vpen_ok ? 8'h00 : ERR_VPEN) | (lock_now ? ERR_LOCK : 8'h00);
    end else begin
      case (st_q)
        ST_IDLE: if (cmd_acc) begin
          case (cmd_code)
            CMD_SETUP: if (err_q == '0 && !prog_susp) begin
              st_q   <= ST_SETUP;
              mode_q <= 1'b1;
            end
            CMD_RDSTAT: mode_q <= 1'b1;
            CMD_CLEAR:  err_q  <= '0;
            CMD_RDARR:  mode_q <= 1'b0;
            default: ;
          endcase
        end
        ST_SETUP: if (cmd_acc) begin
          mode_q <= 1'b1;
          st_q   <= ST_IDLE;
          if (cmd_code == CMD_CONFIRM) begin
            blk_q <= cmd_blk;
            if (lock_mask[cmd_blk])  err_q <= err_q | ERR_ERASE | ERR_LOCK;
            else if (!vpen_ok)       err_q <= err_q | ERR_ERASE | ERR_VPEN;
            else                     st_q  <= ST_RUN;
          end else begin
            err_q <= err_q | ERR_ERASE | ERR_SEQ;
          end
        end
        ST_RUN: if (op_last) begin
          st_q <= ST_IDLE;
        end else if (cmd_acc) begin
          case (cmd_code)
            CMD_SUSPEND: st_q   <= ST_SUSP;
            CMD_RDSTAT:  mode_q <= 1'b1;
            CMD_RDARR:   mode_q <= 1'b0;
            default: ;
          endcase
        end
        ST_SUSP: if (cmd_acc) begin
          case (cmd_code)
            CMD_CONFIRM: st_q   <= ST_RUN;
            CMD_RDSTAT:  mode_q <= 1'b1;
            CMD_RDARR:   mode_q <= 1'b0;
            default: ;
          endcase
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/blk_erase_ctrl.sv
`timescale 1ns/1ps
module blk_erase_ctrl
  import bec_pkg::*;
#(
  parameter int DATA_W        = 16,
  parameter int NUM_BLKS      = 4,
  parameter int WORDS_PER_BLK = 8,
  parameter int PHASE_CYCLES  = 16,
  parameter logic [DATA_W-1:0] INVALID_WORD = DATA_W'(16'hDEAD),
  parameter logic [DATA_W-1:0] GARBAGE_WORD = DATA_W'(16'h5A5A),
  localparam int BLK_W  = $clog2(NUM_BLKS),
  localparam int ADDR_W = BLK_W + $clog2(WORDS_PER_BLK)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                dev_rst,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic [7:0]          cmd_code,
  input  logic [BLK_W-1:0]    cmd_blk,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [DATA_W-1:0]   rd_data,
  input  logic                vpen_ok,
  input  logic                prog_susp,
  input  logic [NUM_BLKS-1:0] lock_mask,
  output logic                sts_ready
);
  seq_state_e        state_w;
  logic [7:0]        status_w;
  logic              mode_stat_w, start_w, advance_w, garbage_w;
  logic [BLK_W-1:0]  blk_w;
  phase_e            phase_w;
  logic              phase_end_w, zero_fill, ones_fill, last_w;
  logic              fill_en;
  logic [DATA_W-1:0] fill_val, arr_word;

  assign cmd_ready = !dev_rst;

  bec_seq #(.NUM_BLKS(NUM_BLKS)) u_seq (
    .clk(clk), .rst_n(rst_n), .dev_rst(dev_rst),
    .cmd_acc(cmd_valid && cmd_ready), .cmd_code(cmd_code), .cmd_blk(cmd_blk),
    .vpen_ok(vpen_ok), .prog_susp(prog_susp), .lock_mask(lock_mask),
    .op_last(last_w), .state_o(state_w), .status_o(status_w),
    .mode_stat_o(mode_stat_w), .blk_o(blk_w), .start_o(start_w),
    .advance_o(advance_w), .garbage_o(garbage_w)
  );

  bec_timer #(.PHASE_CYCLES(PHASE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start_w), .advance(advance_w),
    .phase(phase_w), .phase_end(phase_end_w)
  );

  assign zero_fill = phase_end_w && (phase_w == PH_PRE);
  assign ones_fill = phase_end_w && (phase_w == PH_ERASE);
  assign last_w    = phase_end_w && (phase_w == PH_VERIFY);
  assign fill_en   = garbage_w || zero_fill || ones_fill;
  assign fill_val  = garbage_w ? GARBAGE_WORD : (zero_fill ? '0 : '1);

  bec_array #(.DATA_W(DATA_W), .NUM_BLKS(NUM_BLKS), .WORDS_PER_BLK(WORDS_PER_BLK)) u_array (
    .clk(clk), .rst_n(rst_n), .fill_en(fill_en), .fill_blk(blk_w),
    .fill_val(fill_val), .rd_addr(rd_addr), .rd_word(arr_word)
  );

  assign sts_ready = (state_w != ST_RUN);

  always_comb begin
    if (mode_stat_w)             rd_data = DATA_W'(status_w);
    else if (state_w == ST_RUN)  rd_data = INVALID_WORD;
    else                         rd_data = arr_word;
  end
endmodule

// File: rtl/bec_checker.sv
`timescale 1ns/1ps
module bec_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       dev_rst,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [7:0] cmd_code,
  input logic       sts_ready,
  input logic       sr_susp,
  input logic       sr_erase,
  input logic       sr_seq,
  input logic       sr_vpen,
  input logic       sr_lock
);
  assert_busy_from_confirm_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sts_ready) |-> $past(cmd_valid && cmd_ready && cmd_code == 8'hD0));

  assert_suspend_is_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sr_susp |-> sts_ready);

  assert_lock_flags_erase_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr_lock) |-> sr_erase);

  assert_vpen_flags_erase_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr_vpen) |-> sr_erase);

  assert_seq_flags_erase_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr_seq) |-> sr_erase);

  assert_no_errors_while_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !sts_ready |-> !(sr_erase || sr_seq || sr_vpen || sr_lock));

  assert_ready_after_reset_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dev_rst) |-> sts_ready);
endmodule

bind blk_erase_ctrl bec_checker u_chk (
  .clk(clk), .rst_n(rst_n), .dev_rst(dev_rst), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .cmd_code(cmd_code), .sts_ready(sts_ready),
  .sr_susp(status_w[6]), .sr_erase(status_w[5]), .sr_seq(status_w[4]),
  .sr_vpen(status_w[3]), .sr_lock(status_w[1])
);

// File: tb/blk_erase_ctrl_tb_top.sv
`timescale 1ns/1ps
module blk_erase_ctrl_tb_top;
  localparam int P     = 16;
  localparam int WPB   = 8;
  localparam int NB    = 4;
  localparam int DEPTH = NB * WPB;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0, dev_rst = 1'b0, cmd_valid = 1'b0;
  logic        cmd_ready, sts_ready;
  logic [7:0]  cmd_code = 8'h00;
  logic [1:0]  cmd_blk = 2'd0;
  logic [4:0]  rd_addr = 5'd0;
  logic [15:0] rd_data;
  logic        vpen_ok = 1'b1, prog_susp = 1'b0;
  logic [3:0]  lock_mask = 4'b0;

  int    total = 0, bad = 0;
  bit    closed = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  blk_erase_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .dev_rst(dev_rst), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_code(cmd_code), .cmd_blk(cmd_blk),
    .rd_addr(rd_addr), .rd_data(rd_data), .vpen_ok(vpen_ok),
    .prog_susp(prog_susp), .lock_mask(lock_mask), .sts_ready(sts_ready)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Behavioural reference: remaining-cycle counter and a word list.
  int m_state = 0, m_left = 0, m_blk = 0, m_err = 0;
  bit m_stat = 0;
  int m_arr [DEPTH];

  function automatic int seed(input int i);
    return 32'h4000 + (i / WPB) * 32'h100 + (i % WPB);
  endfunction

  task automatic m_fill(input int b, input int v);
    for (int w = 0; w < WPB; w++) m_arr[b * WPB + w] = v;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_err = 0; m_stat = 0; m_left = 0; m_blk = 0;
      for (int i = 0; i < DEPTH; i++) m_arr[i] = seed(i);
    end else if (dev_rst) begin
      if (m_state >= 2) m_fill(m_blk, 16'h5A5A);
      m_state = 0; m_err = 0; m_stat = 0;
    end else if (m_state >= 2 && (!vpen_ok || lock_mask[m_blk])) begin
      m_err = m_err | 32'h20 | (!vpen_ok ? 32'h08 : 0) | (lock_mask[m_blk] ? 32'h02 : 0);
      m_state = 0;
    end else begin
      case (m_state)
        0: if (cmd_valid) begin
          if (cmd_code == 8'h20 && m_err == 0 && !prog_susp) begin m_state = 1; m_stat = 1; end
          else if (cmd_code == 8'h70) m_stat = 1;
          else if (cmd_code == 8'h50) m_err = 0;
          else if (cmd_code == 8'hFF) m_stat = 0;
        end
        1: if (cmd_valid) begin
          m_stat = 1; m_state = 0;
          if (cmd_code == 8'hD0) begin
            m_blk = int'(cmd_blk);
            if (lock_mask[m_blk]) m_err = m_err | 32'h22;
            else if (!vpen_ok)    m_err = m_err | 32'h28;
            else begin m_state = 2; m_left = 3 * P; end
          end else m_err = m_err | 32'h30;
        end
        2: begin
          m_left--;
          if (3 * P - m_left == P)     m_fill(m_blk, 0);
          if (3 * P - m_left == 2 * P) m_fill(m_blk, 16'hFFFF);
          if (m_left == 0) m_state = 0;
          else if (cmd_valid) begin
            if (cmd_code == 8'hB0) m_state = 3;
            else if (cmd_code == 8'h70) m_stat = 1;
            else if (cmd_code == 8'hFF) m_stat = 0;
          end
        end
        default: if (cmd_valid) begin
          if (cmd_code == 8'hD0) m_state = 2;
          else if (cmd_code == 8'h70) m_stat = 1;
          else if (cmd_code == 8'hFF) m_stat = 0;
        end
      endcase
    end
  end

  always @(negedge clk) begin
    #1;
    if (rst_n && !closed) begin
      int st;
      int exp_rd;
      st = (m_state != 2 ? 32'h80 : 0) | (m_state == 3 ? 32'h40 : 0) | m_err;
      exp_rd = m_stat ? st : (m_state == 2 ? 32'hDEAD : m_arr[rd_addr]);
      chk({cur_req, " model sts_ready"}, 32'(sts_ready), 32'(m_state != 2));
      chk("R13 model cmd_ready", 32'(cmd_ready), 32'(!dev_rst));
      chk({cur_req, " model rd_data"}, 32'(rd_data), exp_rd);
    end
  end

  task automatic cmd(input logic [7:0] c, input int b);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = c; cmd_blk = 2'(b);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic rdchk(input int a, input int exp, input string req);
    @(negedge clk);
    rd_addr = 5'(a);
    #2;
    chk(req, 32'(rd_data), exp);
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!sts_ready && n < 1000) begin n++; @(negedge clk); end
  endtask

  initial begin
    #(200000 * 5);
    if (!closed) begin
      closed = 1;
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rdchk(0, 16'h4000, "R1 seed word 0");
    rdchk(9, 16'h4101, "R1 seed word 9");
    chk("R1 ready after reset", 32'(sts_ready), 1);

    // R2/R4 plain erase of block 2
    cur_req = "R2";
    cmd(8'h20, 2);
    #1 chk("R4 status after setup", 32'(rd_data), 16'h0080);
    cmd(8'hD0, 2);
    #1 chk("R4 status busy", 32'(rd_data), 16'h0000);
    wait_ready(n);
    chk("R2 busy length", n, 3 * P);
    #1 chk("R4 status kept after done", 32'(rd_data), 16'h0080);
    cmd(8'hFF, 0);
    rdchk(16, 16'hFFFF, "R2 block2 first word");
    rdchk(23, 16'hFFFF, "R2 block2 last word");
    rdchk(15, 16'h4107, "R2 block1 untouched");

    // R3/R5/R6 suspend inside erase phase, resume
    cur_req = "R6";
    cmd(8'h20, 1);
    cmd(8'hD0, 1);
    repeat (P + 3) @(negedge clk);
    cmd(8'hB0, 1);
    #1 chk("R6 ready when suspended", 32'(sts_ready), 1);
    chk("R6 suspend status", 32'(rd_data), 16'h00C0);
    cmd(8'hFF, 0);
    rdchk(8, 16'h0000, "R3 precondition zeros");
    rdchk(12, 16'h0000, "R3 precondition zeros mid");
    rdchk(0, 16'h4000, "R6 other block valid in suspend");
    cmd(8'h70, 0);
    cmd(8'hD0, 1);
    cur_req = "R5";
    cmd(8'h50, 0);
    cmd(8'h20, 0);
    cmd(8'hD0, 0);
    #1 chk("R5 ignored cmds keep busy", 32'(sts_ready), 0);
    chk("R5 status unchanged", 32'(rd_data), 16'h0000);
    cmd(8'hFF, 0);
    #1 chk("R5 invalid marker in run", 32'(rd_data), 16'hDEAD);
    wait_ready(n);
    rdchk(8, 16'hFFFF, "R6 resumed erase completes");

    // R7 locked confirm, R10 sticky errors
    cur_req = "R7";
    lock_mask = 4'b0001;
    cmd(8'h20, 0);
    cmd(8'hD0, 0);
    #1 chk("R7 lock error status", 32'(rd_data), 16'h00A2);
    cmd(8'hFF, 0);
    rdchk(0, 16'h4000, "R7 locked block untouched");
    cur_req = "R10";
    cmd(8'h20, 3);
    #1 chk("R10 setup ignored with error", 32'(rd_data), 16'h4000);
    cmd(8'hD0, 3);
    #1 chk("R10 no erase with error", 32'(sts_ready), 1);
    cmd(8'h70, 0);
    #1 chk("R10 error still set", 32'(rd_data), 16'h00A2);
    cmd(8'h50, 0);
    #1 chk("R10 cleared", 32'(rd_data), 16'h0080);
    lock_mask = 4'b0000;
    cur_req = "R7";
    cmd(8'h20, 3);
    cmd(8'hD0, 3);
    repeat (3) @(negedge clk);
    lock_mask = 4'b1000;
    @(negedge clk);
    #1 chk("R7 lock during run aborts", 32'(rd_data), 16'h00A2);
    lock_mask = 4'b0000;
    cmd(8'h50, 0);

    // R8 voltage
    cur_req = "R8";
    vpen_ok = 1'b0;
    cmd(8'h20, 2);
    cmd(8'hD0, 2);
    #1 chk("R8 voltage at confirm", 32'(rd_data), 16'h00A8);
    vpen_ok = 1'b1;
    cmd(8'h50, 0);
    cmd(8'h20, 2);
    cmd(8'hD0, 2);
    repeat (2) @(negedge clk);
    cmd(8'hB0, 2);
    vpen_ok = 1'b0;
    @(negedge clk);
    #1 chk("R8 voltage drop in suspend", 32'(rd_data), 16'h00A8);
    vpen_ok = 1'b1;
    cmd(8'h50, 0);

    // R9 bad sequence
    cur_req = "R9";
    cmd(8'h20, 1);
    cmd(8'h70, 1);
    #1 chk("R9 sequence error", 32'(rd_data), 16'h00B0);
    cmd(8'h50, 0);
    #1 chk("R9 cleared", 32'(rd_data), 16'h0080);

    // R11 program suspended
    cur_req = "R11";
    cmd(8'hFF, 0);
    rd_addr = 5'd8;
    prog_susp = 1'b1;
    cmd(8'h20, 1);
    #1 chk("R11 setup ignored", 32'(rd_data), 16'hFFFF);
    cmd(8'hD0, 1);
    #1 chk("R11 no erase", 32'(sts_ready), 1);
    prog_susp = 1'b0;

    // R12/R13 device reset mid-erase with a refused command
    cur_req = "R12";
    cmd(8'h20, 1);
    cmd(8'hD0, 1);
    repeat (4) @(negedge clk);
    dev_rst = 1'b1; cmd_valid = 1'b1; cmd_code = 8'h70;
    #1 chk("R13 not ready in reset", 32'(cmd_ready), 0);
    @(negedge clk);
    dev_rst = 1'b0; cmd_valid = 1'b0;
    rd_addr = 5'd11;
    #1 chk("R12 ready after reset", 32'(sts_ready), 1);
    chk("R12 garbage fill, R13 cmd refused", 32'(rd_data), 16'h5A5A);
    rdchk(16, 16'hFFFF, "R12 other block kept");

    repeat (2) @(negedge clk);
    closed = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule